// File: doc/BRIEF.md
# SPI Mode-3 Slave Frame Interface

This block is the serial front end of a peripheral controller. A host master talks to it over SPI with a fixed clock shape. The serial clock idles high. Both sides change data on the falling edge and sample on the rising edge. Bits travel most significant first in both directions.

One low period of the active-low select line forms a frame, and a frame can hold any whole number of bytes back to back. The block oversamples the serial clock, data and select inputs with the system clock and finds their edges there. Each byte received is handed to the core with a one-cycle strobe. The next byte to send is taken from the core when the block requests it.

The data output comes with a separate enable, so the pad can be tristated. That enable is released whenever select is high. When select rises the block reports the end of the frame. If a byte was cut short, it also flags an error so the core can discard the frame.

Top module: `spi_m3_slave`

## Requirements
- R1: After reset the block is idle: `miso_oe`, `rx_valid`, `tx_req`, `frame_end` and `frame_error` are low and `rx_data` is zero.
- R2: While `ss_n` is high, `miso_oe` is low and SCLK/MOSI activity produces no `rx_valid` and no `frame_end`.
- R3: MOSI is sampled on each SCLK rising edge, the first bit of a byte landing in bit 7 of `rx_data`. After the eighth rising edge, `rx_valid` pulses high for exactly one cycle with the byte on `rx_data`. With two synchronizer stages, the pulse appears on the third system clock edge after the raw SCLK rise.
- R4: `tx_req` pulses for exactly one cycle when a frame starts, and again after each completed byte unless select rises in that same cycle. `tx_data` is captured at the end of the cycle in which `tx_req` is high.
- R5: `miso` shows bit 7 of the captured byte before the first SCLK falling edge of that byte. It then moves to the next lower bit on every later SCLK falling edge within the byte, so the master reads the byte most significant bit first.
- R6: Several bytes in one select assertion are exchanged back to back, each with its own `rx_valid` and `tx_req`.
- R7: Every rising edge of `ss_n` during a frame produces a one-cycle `frame_end` pulse, and the block then returns to idle.
- R8: If select rises after 1 to 7 bits of a byte, `frame_error` pulses in the same cycle as `frame_end` and the partial byte never raises `rx_valid`.
- R9: If select rises in the same cycle in which a byte completes, `rx_valid` and `frame_end` pulse together, `frame_error` stays low and no `tx_req` is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle high |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for the MISO pad |
| rx_data | output | DATA_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| tx_data | input | DATA_W | Next byte to transmit, held by the core |
| tx_req | output | 1 | One-cycle request; `tx_data` is captured at its end |
| frame_end | output | 1 | One-cycle pulse on select deassertion |
| frame_error | output | 1 | One-cycle pulse when the frame ended mid-byte |

## Verification
Completion of a byte and the end of a frame can land in the same system cycle. They collide when the master deasserts select at the same moment it gives the eighth rising clock edge. The bench provokes this by changing both inputs on one clock edge. The two then pass through the synchronizer together and are detected in the same cycle. The cycle-by-cycle model predicts that `rx_valid` and `frame_end` are high in that cycle, with `frame_error` and `tx_req` low. The bench also counts coincident pulses and checks that the byte still reaches the received list.

// File: rtl/spi_m3_pkg.sv
package spi_m3_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_FEND  = 2'd2
   } spi_m3_state_e;

   localparam int SYNC_MIN = 2;
   localparam int DATA_MIN = 2;

endpackage

// File: rtl/spi_m3_sync.sv
module spi_m3_sync #(
   parameter int                 WIDTH   = 1,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = STAGES * WIDTH;

   generate
      if (STAGES < spi_m3_pkg::SYNC_MIN) begin : g_bad_stages
         $error("spi_m3_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_m3_sync: WIDTH must be positive");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[CHAIN_W-WIDTH-1:0], d};
      end
   end

   assign q = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/spi_m3_edge.sv
module spi_m3_edge #(
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d <= IDLE_VAL;
      end else begin
         lvl_d <= lvl;
      end
   end

   assign rise = lvl & ~lvl_d;
   assign fall = ~lvl & lvl_d;

endmodule

// File: rtl/spi_m3_shreg.sv
module spi_m3_shreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              tx_adv,
   input  logic              rx_adv,
   input  logic              rx_bit,
   output logic              tx_bit,
   output logic [DATA_W-1:0] rx_word
);
   generate
      if (DATA_W < spi_m3_pkg::DATA_MIN) begin : g_bad_width
         $error("spi_m3_shreg: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
      end else if (load) begin
         tx_sh <= load_val;
      end else if (tx_adv) begin
         tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh <= '0;
      end else if (rx_adv) begin
         rx_sh <= {rx_sh[DATA_W-2:0], rx_bit};
      end
   end

   assign tx_bit  = tx_sh[DATA_W-1];
   assign rx_word = rx_sh;

endmodule

// File: rtl/spi_m3_slave.sv
module spi_m3_slave #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              mosi,
   input  logic              ss_n,
   output logic              miso,
   output logic              miso_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_req,
   output logic              frame_end,
   output logic              frame_error
);
   import spi_m3_pkg::*;

   localparam int               CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < DATA_MIN) begin : g_bad_data
         $error("spi_m3_slave: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < SYNC_MIN) begin : g_bad_sync
         $error("spi_m3_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // synchronized pins: {ss_n, mosi, sclk}, idle levels high/low/high
   logic [2:0] pins_s;
   logic       s_sclk, s_mosi, s_ss_n;

   spi_m3_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b101)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ss_n, mosi, sclk}),
      .q     (pins_s)
   );

   assign s_sclk = pins_s[0];
   assign s_mosi = pins_s[1];
   assign s_ss_n = pins_s[2];

   logic sclk_rise, sclk_fall;

   spi_m3_edge #(.IDLE_VAL(1'b1)) i_sclk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (s_sclk),
      .rise  (sclk_rise),
      .fall  (sclk_fall)
   );

   logic ss_d;
   logic ss_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_d <= 1'b1;
      end else begin
         ss_d <= s_ss_n;
      end
   end

   assign ss_rise = s_ss_n & ~ss_d;

   spi_m3_state_e    state;
   logic [CNT_W-1:0] bit_cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             in_shift;
   logic             byte_done;
   logic             tx_adv;
   logic             rx_adv;
   logic             tx_bit;
   logic [DATA_W-1:0] rx_word;

   assign in_shift  = (state == ST_SHIFT);
   assign byte_done = in_shift & sclk_rise & (bit_cnt == LAST_BIT);
   assign rx_adv    = in_shift & sclk_rise;
   assign tx_adv    = in_shift & sclk_fall & (bit_cnt != '0);

   always_comb begin
      cnt_nxt = bit_cnt;
      if (sclk_rise) begin
         cnt_nxt = (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      end
   end

   spi_m3_shreg #(.DATA_W(DATA_W)) i_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tx_req),
      .load_val (tx_data),
      .tx_adv   (tx_adv),
      .rx_adv   (rx_adv),
      .rx_bit   (s_mosi),
      .tx_bit   (tx_bit),
      .rx_word  (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bit_cnt     <= '0;
         rx_data     <= '0;
         rx_valid    <= 1'b0;
         tx_req      <= 1'b0;
         frame_end   <= 1'b0;
         frame_error <= 1'b0;
      end else begin
         rx_valid    <= 1'b0;
         tx_req      <= 1'b0;
         frame_end   <= 1'b0;
         frame_error <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (!s_ss_n) begin
                  state   <= ST_SHIFT;
                  bit_cnt <= '0;
                  tx_req  <= 1'b1;
               end
            end
            ST_SHIFT: begin
               if (byte_done) begin
                  rx_valid <= 1'b1;
                  rx_data  <= {rx_word[DATA_W-2:0], s_mosi};
               end
               if (ss_rise) begin
                  state       <= ST_FEND;
                  frame_end   <= 1'b1;
                  frame_error <= (cnt_nxt != '0);
                  bit_cnt     <= '0;
               end else begin
                  bit_cnt <= cnt_nxt;
                  if (byte_done) begin
                     tx_req <= 1'b1;
                  end
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   assign miso    = tx_bit;
   assign miso_oe = in_shift & ~ss_n;

endmodule

// File: rtl/spi_m3_slave_chk.sv
module spi_m3_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_valid,
   input logic tx_req,
   input logic frame_end,
   input logic frame_error
);
   // R3: strobe lasts one cycle
   a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R4: request lasts one cycle
   a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);

   // R7: frame end lasts one cycle
   a_r7_end_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end);

   // R8: an error only accompanies a frame end
   a_r8_err_with_end: assert property (@(posedge clk) disable iff (!rst_n)
      frame_error |-> frame_end);

   // R9: no new byte is requested when the frame closes
   a_r9_no_req_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> !tx_req);

endmodule

bind spi_m3_slave spi_m3_slave_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_valid    (rx_valid),
   .tx_req      (tx_req),
   .frame_end   (frame_end),
   .frame_error (frame_error)
);

// File: tb/test_spi_m3_slave.sv
module test_spi_m3_slave;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCK   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b1;
   logic       mosi = 1'b0;
   logic       ss_n = 1'b1;
   logic       miso, miso_oe, rx_valid, tx_req, frame_end, frame_error;
   logic [7:0] rx_data;
   logic [7:0] tx_data = 8'hA5;

   int n_chk = 0;
   int n_err = 0;

   spi_m3_slave #(.DATA_W(8), .SYNC_STAGES(2)) i_spi_m3_slave (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
      .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data), .rx_valid(rx_valid),
      .tx_data(tx_data), .tx_req(tx_req), .frame_end(frame_end),
      .frame_error(frame_error)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // behavioural reference model, advanced on every rising clock edge
   int m_state = 0, m_cnt = 0, m_rx_sh = 0, m_rx_data = 0, m_tx_sh = 0;
   bit m_rxv = 0, m_txr = 0, m_fe = 0, m_ferr = 0;
   bit p_sclk[$], p_mosi[$], p_ss[$];
   bit d_sclk = 1, d_ss = 1;

   always @(posedge clk) begin : model
      bit rs, fl, sr, done, ssc, ssm, sss;
      int cn;
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_rx_sh = 0; m_rx_data = 0; m_tx_sh = 0;
         m_rxv = 0; m_txr = 0; m_fe = 0; m_ferr = 0;
         p_sclk = '{1, 1}; p_mosi = '{0, 0}; p_ss = '{1, 1};
         d_sclk = 1; d_ss = 1;
      end else begin
         ssc = p_sclk[0]; ssm = p_mosi[0]; sss = p_ss[0];
         rs = ssc && !d_sclk;
         fl = !ssc && d_sclk;
         sr = sss && !d_ss;
         if (m_txr) m_tx_sh = tx_data;
         else if (m_state == 1 && fl && m_cnt != 0) m_tx_sh = (m_tx_sh << 1) & 255;
         m_rxv = 0; m_fe = 0; m_ferr = 0;
         begin : fsm
            bit nreq;
            nreq = 0;
            if (m_state == 0) begin
               if (!sss) begin m_state = 1; m_cnt = 0; nreq = 1; end
            end else if (m_state == 1) begin
               done = rs && (m_cnt == 7);
               cn = rs ? ((m_cnt == 7) ? 0 : m_cnt + 1) : m_cnt;
               if (rs) m_rx_sh = ((m_rx_sh << 1) | int'(ssm)) & 255;
               if (done) begin m_rxv = 1; m_rx_data = m_rx_sh; end
               if (sr) begin
                  m_state = 2; m_fe = 1; m_ferr = (cn != 0); m_cnt = 0;
               end else begin
                  m_cnt = cn;
                  if (done) nreq = 1;
               end
            end else begin
               m_state = 0;
            end
            m_txr = nreq;
         end
         d_sclk = ssc; d_ss = sss;
         void'(p_sclk.pop_front()); p_sclk.push_back(sclk);
         void'(p_mosi.pop_front()); p_mosi.push_back(mosi);
         void'(p_ss.pop_front());   p_ss.push_back(ss_n);
      end
   end

   // monitor: compare every cycle away from the edge, emulate the core
   logic [7:0] rx_got[$];
   logic [7:0] tx_hist[$];
   int  n_fe = 0, n_ferr = 0, n_coin = 0;
   bit  req_prev = 0;

   always @(negedge clk) begin
      #1;
      check("R2 miso_oe", int'(miso_oe), int'((m_state == 1) && !ss_n));
      if (miso_oe) check("R5 miso", int'(miso), (m_tx_sh >> 7) & 1);
      check("R3 rx_valid", int'(rx_valid), int'(m_rxv));
      check("R3 rx_data", int'(rx_data), m_rx_data);
      check("R4 tx_req", int'(tx_req), int'(m_txr));
      check("R7 frame_end", int'(frame_end), int'(m_fe));
      check("R8 frame_error", int'(frame_error), int'(m_ferr));
      if (rx_valid) rx_got.push_back(rx_data);
      if (frame_end) n_fe++;
      if (frame_error) n_ferr++;
      if (rx_valid && frame_end) n_coin++;
      if (req_prev) tx_data = tx_data + 8'h3B;
      if (tx_req) tx_hist.push_back(tx_data);
      req_prev = tx_req;
   end

   // master side
   logic [7:0] got_byte;

   task automatic xfer_byte(input logic [7:0] mo, input bit close_at_end);
      for (int i = 7; i >= 0; i--) begin
         sclk = 1'b0;
         mosi = mo[i];
         repeat (HALF_SCK) @(negedge clk);
         got_byte[i] = miso;
         sclk = 1'b1;
         if (i == 0 && close_at_end) ss_n = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
      end
   endtask

   task automatic open_frame();
      tx_hist.delete();
      rx_got.delete();
      ss_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic close_frame();
      repeat (2) @(negedge clk);
      ss_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input int nb, input bit coincide);
      logic [7:0] bs[3];
      logic [7:0] exp_tx;
      bs[0] = b0; bs[1] = b1; bs[2] = b2;
      open_frame();
      for (int k = 0; k < nb; k++) begin
         xfer_byte(bs[k], coincide && (k == nb - 1));
         exp_tx = tx_hist.pop_front();
         check("R5 master byte", int'(got_byte), int'(exp_tx));
      end
      if (coincide) repeat (8) @(negedge clk);
      else close_frame();
      check("R6 byte count", rx_got.size(), nb);
      for (int k = 0; k < nb && k < rx_got.size(); k++)
         check("R3 received byte", int'(rx_got[k]), int'(bs[k]));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : stim
      int fe0, ferr0, rx0, coin0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 miso_oe", int'(miso_oe), 0);
      check("R1 rx_valid", int'(rx_valid), 0);
      check("R1 tx_req", int'(tx_req), 0);
      check("R1 frame_end", int'(frame_end), 0);
      check("R1 frame_error", int'(frame_error), 0);
      check("R1 rx_data", int'(rx_data), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2: activity with select high is ignored
      rx0 = rx_got.size(); fe0 = n_fe;
      for (int i = 0; i < 12; i++) begin
         sclk = 1'b0; mosi = i[0];
         repeat (HALF_SCK) @(negedge clk);
         sclk = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      check("R2 no rx while deselected", rx_got.size(), rx0);
      check("R2 no frame_end while deselected", n_fe, fe0);
      check("R2 oe low", int'(miso_oe), 0);

      // R3 R5 R7: single byte frame
      fe0 = n_fe;
      run_frame(8'h3C, 8'h00, 8'h00, 1, 1'b0);
      check("R7 frame_end count", n_fe, fe0 + 1);

      // R6: three byte frame
      ferr0 = n_ferr;
      run_frame(8'h81, 8'h7E, 8'h55, 3, 1'b0);
      check("R8 no error on whole frame", n_ferr, ferr0);

      // R8: select rises after three bits
      open_frame();
      ferr0 = n_ferr; fe0 = n_fe;
      for (int i = 0; i < 3; i++) begin
         sclk = 1'b0; mosi = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
         sclk = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
      end
      close_frame();
      check("R8 error pulse", n_ferr, ferr0 + 1);
      check("R8 frame_end with error", n_fe, fe0 + 1);
      check("R8 partial byte dropped", rx_got.size(), 0);
      check("R7 idle after end", int'(miso_oe), 0);

      // R9: byte completes as select rises
      coin0 = n_coin; ferr0 = n_ferr;
      run_frame(8'hC3, 8'h9A, 8'h00, 2, 1'b1);
      check("R9 coincident pulses", n_coin, coin0 + 1);
      check("R9 no error", n_ferr, ferr0);

      // R4: recovery frame after the coincidence
      run_frame(8'hF0, 8'h0F, 8'h00, 2, 1'b0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule